// File: doc/BRIEF.md
# Keyboard Scan Code Event Decoder

This block sits behind a serial keyboard frame receiver. The receiver hands over one byte at a time. Each byte comes with a single-cycle valid pulse and an error flag. The decoder turns this byte stream into key events. Each event carries a key code, an extended-key flag, a released flag, a repeat flag and a one-cycle strobe.

A press arrives as a single code byte. A release arrives as a break prefix followed by the code. Keys from the extended set add an extended prefix in front of either sequence. The decoder stores the prefixes as pending flags and applies them to the next code byte. It then reports that byte as one event. While a key is held, the keyboard resends its code; each resend is reported as a press with the repeat flag set. Bytes marked as errors are dropped, and they leave every piece of decoder state as it was.

Top module: `key_event_decoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `evt_valid` is 0. Reset clears any pending prefix. It also clears the remembered last press, so the first press after reset has `evt_rpt` = 0.
- R2: A byte with `byte_err` = 1 produces no event. It also does not change the pending prefixes or the repeat memory.
- R3: An accepted byte other than 0xF0 and 0xE0 is a code byte. It raises `evt_valid` in the cycle after it is accepted, with `evt_code` equal to the byte. With no prefix pending, `evt_rel` = 0 and `evt_ext` = 0.
- R4: A break prefix 0xF0 followed by a code byte yields a single event with `evt_rel` = 1.
- R5: An extended prefix 0xE0 ahead of a code byte sets `evt_ext` = 1. The sequence 0xE0, 0xF0, code yields one event with both `evt_ext` and `evt_rel` set.
- R6: Prefix bytes 0xF0 and 0xE0 produce no event of their own.
- R7: Both pending prefix flags clear once a code byte is taken, so the next code byte is reported without them.
- R8: `evt_valid` is high for one cycle per code byte. `evt_code`, `evt_ext`, `evt_rel` and `evt_rpt` keep their values until the next event.
- R9: `evt_rpt` = 1 on a press whose code and extended flag equal those of the previous press, with no release event in between. A release event always has `evt_rpt` = 0 and forgets the remembered press.
- R10: Cycles with `byte_valid` = 0 are ignored whatever `byte_data` holds. Bytes may arrive on back-to-back cycles or with idle gaps between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | One-cycle strobe for `byte_data` |
| byte_err | input | 1 | Frame error flag for the current byte |
| byte_data | input | 8 | Received byte |
| evt_valid | output | 1 | One-cycle key event strobe |
| evt_code | output | 8 | Key code of the latest event |
| evt_ext | output | 1 | Latest event belongs to the extended key set |
| evt_rel | output | 1 | Latest event is a release |
| evt_rpt | output | 1 | Latest event is a repeated press |

## Verification
A stuck or leaked prefix flag shows up on the next code byte, one cycle after that byte is accepted, as a wrong `evt_rel` or `evt_ext`. A wrong repeat memory shows on the first press after a release, after a reset, or after a change of extended flag, as a wrong `evt_rpt`. A reference model in the bench follows every accepted byte and compares all five outputs on every cycle. Any such fault is therefore reported in the cycle of the first event that exposes it.

// File: rtl/kbd_evt_pkg.sv
package kbd_evt_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [BYTE_W-1:0] PFX_BREAK = 8'hF0;
    localparam logic [BYTE_W-1:0] PFX_EXT   = 8'hE0;

    typedef enum logic [1:0] {
        KIND_CODE  = 2'd0,
        KIND_BREAK = 2'd1,
        KIND_EXT   = 2'd2
    } byte_kind_e;

    typedef struct packed {
        logic              ext;
        logic [BYTE_W-1:0] code;
    } key_id_t;

    typedef struct packed {
        key_id_t key;
        logic    rel;
        logic    rpt;
    } key_evt_t;

    function automatic byte_kind_e classify(input logic [BYTE_W-1:0] b);
        if (b == PFX_BREAK)    return KIND_BREAK;
        else if (b == PFX_EXT) return KIND_EXT;
        else                   return KIND_CODE;
    endfunction

endpackage

// File: rtl/kd_prefix_track.sv
module kd_prefix_track
    import kbd_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [BYTE_W-1:0] din,
    output logic              code_take,
    output logic              brk_pend,
    output logic              ext_pend
);

    byte_kind_e kind;

    assign kind      = classify(din);
    assign code_take = take && (kind == KIND_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_pend <= 1'b0;
            ext_pend <= 1'b0;
        end else if (take) begin
            case (kind)
                KIND_BREAK: brk_pend <= 1'b1;
                KIND_EXT:   ext_pend <= 1'b1;
                default: begin
                    brk_pend <= 1'b0;
                    ext_pend <= 1'b0;
                end
            endcase
        end
    end

    AST_PFX_CLEAR_AFTER_CODE: assert property (@(posedge clk) disable iff (rst)
        $past(code_take) |-> (!brk_pend && !ext_pend)); // R7

    AST_PFX_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(take) |-> ($stable(brk_pend) && $stable(ext_pend))); // R10

endmodule

// File: rtl/kd_repeat_track.sv
module kd_repeat_track
    import kbd_evt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fire,
    input  logic    rel,
    input  key_id_t key,
    output logic    hit
);

    key_id_t last_q;
    logic    armed_q;

    assign hit = fire && !rel && armed_q && (last_q == key);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            last_q  <= '0;
        end else if (fire) begin
            if (rel) begin
                armed_q <= 1'b0;
            end else begin
                armed_q <= 1'b1;
                last_q  <= key;
            end
        end
    end

    AST_RPT_DISARM_ON_REL: assert property (@(posedge clk) disable iff (rst)
        $past(fire && rel) |-> !armed_q); // R9

endmodule

// File: rtl/key_event_decoder.sv
module key_event_decoder
    import kbd_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic              byte_err,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              evt_valid,
    output logic [BYTE_W-1:0] evt_code,
    output logic              evt_ext,
    output logic              evt_rel,
    output logic              evt_rpt
);

    logic     take;
    logic     code_take;
    logic     brk_pend;
    logic     ext_pend;
    logic     rpt_hit;
    key_id_t  cur_key;
    key_evt_t evt_q;

    assign take    = byte_valid && !byte_err;
    assign cur_key = '{ext: ext_pend, code: byte_data};

    kd_prefix_track u_pfx (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .din       (byte_data),
        .code_take (code_take),
        .brk_pend  (brk_pend),
        .ext_pend  (ext_pend)
    );

    kd_repeat_track u_rpt (
        .clk  (clk),
        .rst  (rst),
        .fire (code_take),
        .rel  (brk_pend),
        .key  (cur_key),
        .hit  (rpt_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_valid <= 1'b0;
            evt_q     <= '0;
        end else begin
            evt_valid <= code_take;
            if (code_take) begin
                evt_q <= '{key: cur_key, rel: brk_pend, rpt: rpt_hit};
            end
        end
    end

    assign evt_code = evt_q.key.code;
    assign evt_ext  = evt_q.key.ext;
    assign evt_rel  = evt_q.rel;
    assign evt_rpt  = evt_q.rpt;

    AST_EVT_NEEDS_GOOD_BYTE: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> $past(byte_valid && !byte_err)); // R2

    AST_EVT_CODE_FROM_BYTE: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> (evt_code == $past(byte_data))); // R3

    AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (rst)
        $past(byte_valid && !byte_err &&
              (byte_data == PFX_BREAK || byte_data == PFX_EXT)) |-> !evt_valid); // R6

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !evt_valid |-> ($stable(evt_code) && $stable(evt_ext) &&
                        $stable(evt_rel) && $stable(evt_rpt))); // R8

    AST_NO_RPT_AFTER_REL: assert property (@(posedge clk) disable iff (rst)
        ($past(evt_valid && evt_rel) && evt_valid) |-> !evt_rpt); // R9

endmodule

// File: tb/sim_key_event_decoder.sv
module sim_key_event_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_valid = 1'b0;
    logic       byte_err = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       evt_valid;
    logic [7:0] evt_code;
    logic       evt_ext;
    logic       evt_rel;
    logic       evt_rpt;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    always #4 clk = ~clk;

    key_event_decoder u0 (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_err   (byte_err),
        .byte_data  (byte_data),
        .evt_valid  (evt_valid),
        .evt_code   (evt_code),
        .evt_ext    (evt_ext),
        .evt_rel    (evt_rel),
        .evt_rpt    (evt_rpt)
    );

    // Behavioural reference: pending prefixes as booleans, last press as integer (-1 = none)
    bit   m_valid, m_ext, m_rel, m_rpt;
    int   m_code;
    bit   p_brk, p_ext;
    int   last_press;
    int   key_val;

    always @(posedge clk) begin
        if (rst) begin
            m_valid = 0; m_code = 0; m_ext = 0; m_rel = 0; m_rpt = 0;
            p_brk = 0; p_ext = 0; last_press = -1;
        end else begin
            m_valid = 0;
            if (byte_valid && !byte_err) begin
                if (byte_data == 8'hF0) p_brk = 1;
                else if (byte_data == 8'hE0) p_ext = 1;
                else begin
                    key_val = int'(byte_data) + (p_ext ? 256 : 0);
                    m_valid = 1;
                    m_code  = int'(byte_data);
                    m_ext   = p_ext;
                    m_rel   = p_brk;
                    if (p_brk) begin
                        m_rpt = 0;
                        last_press = -1;
                    end else begin
                        m_rpt = (last_press == key_val);
                        last_press = key_val;
                    end
                    p_brk = 0; p_ext = 0;
                end
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                // R1: no event while reset is held
                check("R1", "evt_valid in reset", int'(evt_valid), 0);
            end else begin
                check(cur_req, "evt_valid", int'(evt_valid), int'(m_valid));
                check(cur_req, "evt_code",  int'(evt_code),  m_code);
                check(cur_req, "evt_ext",   int'(evt_ext),   int'(m_ext));
                check(cur_req, "evt_rel",   int'(evt_rel),   int'(m_rel));
                check(cur_req, "evt_rpt",   int'(evt_rpt),   int'(m_rpt));
            end
        end
    end

    task automatic send(input logic [7:0] b, input logic e, input string r);
        @(negedge clk);
        cur_req    = r;
        byte_valid = 1'b1;
        byte_err   = e;
        byte_data  = b;
    endtask

    task automatic idle(input int n, input logic [7:0] junk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_valid = 1'b0;
            byte_err   = 1'b0;
            byte_data  = junk;
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(2, 8'h00);

        // R3: single press, then R9 held key repeats
        send(8'h1C, 1'b0, "R3"); idle(2, 8'h00);
        send(8'h1C, 1'b0, "R9"); idle(1, 8'h00);
        send(8'h1C, 1'b0, "R9"); idle(2, 8'h00);

        // R4: break sequence gives one release event
        send(8'hF0, 1'b0, "R6"); idle(3, 8'h00);
        send(8'h1C, 1'b0, "R4"); idle(2, 8'h00);

        // R9: press after release is not a repeat
        send(8'h1C, 1'b0, "R9"); idle(2, 8'h00);

        // R5: extended press, repeat, then extended release back-to-back
        send(8'hE0, 1'b0, "R5"); send(8'h75, 1'b0, "R5"); idle(2, 8'h00);
        send(8'hE0, 1'b0, "R9"); send(8'h75, 1'b0, "R9"); idle(2, 8'h00);
        send(8'h75, 1'b0, "R9"); idle(2, 8'h00);  // same code, no ext: not a repeat
        send(8'hE0, 1'b0, "R5"); send(8'hF0, 1'b0, "R5"); send(8'h75, 1'b0, "R5"); idle(2, 8'h00);

        // R7: flags gone for the following code byte
        send(8'h29, 1'b0, "R7"); idle(2, 8'h00);

        // R2: errored prefix and errored code are dropped
        send(8'hF0, 1'b1, "R2"); send(8'hE0, 1'b1, "R2"); send(8'h2B, 1'b0, "R2"); idle(2, 8'h00);
        send(8'h2B, 1'b1, "R2"); idle(2, 8'h00);
        send(8'h2B, 1'b0, "R2"); idle(2, 8'h00);  // still a repeat of 0x2B

        // R10: junk on the bus with valid low is ignored
        idle(3, 8'hF0);
        idle(3, 8'hE0);
        send(8'h16, 1'b0, "R10"); idle(2, 8'hF0);

        // R8: fields hold across long idle
        idle(6, 8'h55);

        // R1: reset with a pending prefix and a remembered press
        send(8'h16, 1'b0, "R1"); send(8'hF0, 1'b0, "R1"); send(8'hE0, 1'b0, "R1");
        @(negedge clk);
        byte_valid = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        idle(1, 8'h00);
        send(8'h16, 1'b0, "R1"); idle(3, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule